// File: doc/BRIEF.md
# CEC Frame Transmitter with Single Retry

This block sends one consumer-electronics-control message of 1 to 16 bytes onto an open-drain CEC line. The host places the bytes in four 32-bit words, sets a length field and raises a level-sensitive start input. The transmitter waits until the line has been quiet for long enough. It then pulls the line low for a start bit and sends each byte as a ten-bit block: eight data bits with the most significant bit first, an end-of-message bit, and an acknowledge slot. At the end it reports a done flag, a success flag and a one-cycle interrupt.

Timing is taken from a divided clock tick. The divider and all pulse widths are given as tick counts on input ports, so one instance works at any system clock frequency. A missing acknowledge causes one automatic resend. A lost bus ends the message at once and nothing is resent. A software-reset input stops any transfer and releases the line.

Top module: `cec_tx`

## Requirements
- R1: After reset the line is released (`cec_drive_o`=0) and `busy_o`, `eom_o`, `good_o` and `irq_o` are all 0.
- R2: `len_m1_i` holds the message length minus one, and exactly `len_m1_i`+1 bytes are sent. Byte k is `msg_i[8k+7:8k]`, which is lane k%4 of word k/4, and byte 0 is sent first.
- R3: Each data byte is sent MSB first. The end-of-message bit is 1 only on the last byte. In the acknowledge slot the transmitter itself sends a 1.
- R4: A transmit starts only when `start_i` is 1 and `start_i` has been 0 at some cycle since the previous start. If `start_i` is simply held high, no further message is sent.
- R5: The start bit of a first attempt begins only after the sensed line has been high for at least 7 bit periods. A retry needs at least 3 bit periods of high line.
- R6: The acknowledge is sampled `t_samp_i` ticks into the acknowledge slot. A sampled low counts as acknowledged. When a byte is not acknowledged, the frame ends after that slot and the whole message is sent once more. `good_o` is 1 if the first or the second attempt is fully acknowledged.
- R7: When a message finishes, whether it succeeded or failed, `busy_o` falls, `eom_o` is set, `good_o` gives the result and `irq_o` pulses for exactly one cycle. The next launch clears `eom_o` and `good_o`.
- R8: When the destination nibble `msg_i[3:0]` is 4'hF (broadcast), the acknowledge sense is inverted: a high line at the sample point means accepted, and a low line means rejected and triggers the retry.
- R9: If the transmitter sends a 1 as a data bit or an end-of-message bit and reads the line low at the sample point, it releases the line and finishes with `good_o`=0. It does not retry.
- R10: While `soft_rst_i` is high, the transfer is aborted, the line is released, `busy_o`, `eom_o` and `good_o` are 0, and the interrupted message is not resumed.
- R11: One tick lasts `div_i`+1 clock cycles. The start bit is low for `t_start_low_i` ticks within a period of `t_start_per_i` ticks. A 0 is low for `t_zero_low_i` ticks and a 1 is low for `t_one_low_i` ticks, each within a period of `t_bit_per_i` ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| soft_rst_i | input | 1 | Aborts transfer and releases line |
| div_i | input | DIV_W | Tick divider; tick every div_i+1 cycles |
| t_start_low_i | input | CNT_W | Start bit low time in ticks |
| t_start_per_i | input | CNT_W | Start bit total period in ticks |
| t_zero_low_i | input | CNT_W | Low time of a 0 bit in ticks |
| t_one_low_i | input | CNT_W | Low time of a 1 bit in ticks |
| t_bit_per_i | input | CNT_W | Bit period in ticks |
| t_samp_i | input | CNT_W | Sample point in ticks from bit start (must be below t_bit_per_i-1) |
| msg_i | input | WORDS*32 | Message bytes, byte k at bits 8k+7:8k |
| len_m1_i | input | log2(WORDS*4) | Message length minus one |
| start_i | input | 1 | Level start request |
| cec_i | input | 1 | Sensed CEC line level |
| cec_drive_o | output | 1 | 1 pulls the line low |
| busy_o | output | 1 | Message in progress |
| eom_o | output | 1 | Message finished |
| good_o | output | 1 | Message acknowledged |
| irq_o | output | 1 | One-cycle completion pulse |

## Verification
The bench sweeps every length from 1 to 16 with distinct byte patterns. A follower model decodes each low pulse into bits and checks byte order, lane selection and the end-of-message position. The same follower is then run under several acknowledge policies: always, never, only on the retry frame, and only on the first frame. Together these separate a missing retry, an extra retry and a wrongly reported result. Broadcast headers are run under the same policies to expose a non-inverted acknowledge sense. A pull-down on a sent 1 separates arbitration loss from a plain negative acknowledge. The gaps between frames tell the 7-period idle rule apart from the 3-period rule. A run with a non-zero divider shows that every width scales with the tick.

// File: rtl/cec_tx_pkg.sv
package cec_tx_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_START, ST_BITS} tx_state_e;
  localparam int unsigned SLOT_EOM   = 8;
  localparam int unsigned SLOT_ACK   = 9;
  localparam int unsigned IDLE_FIRST = 7;
  localparam int unsigned IDLE_RETRY = 3;
  localparam logic [3:0]  BCAST_DEST = 4'hF;
endpackage

// File: rtl/cec_tick_gen.sv
module cec_tick_gen #(
  parameter int unsigned DIV_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = (cnt_q >= div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/cec_byte_sel.sv
module cec_byte_sel #(
  parameter int unsigned WORDS = 4,
  parameter int unsigned IDX_W = 4
) (
  input  logic [WORDS*32-1:0] msg_i,
  input  logic [IDX_W-1:0]    idx_i,
  output logic [7:0]          byte_o
);
  localparam int unsigned NB = WORDS * 4;

  logic [7:0] lane [NB];

  for (genvar k = 0; k < NB; k++) begin : g_lane
    assign lane[k] = msg_i[k*8 +: 8];
  end

  assign byte_o = lane[idx_i];
endmodule

// File: rtl/cec_line_mon.sv
module cec_line_mon #(
  parameter int unsigned IDLE_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              cec_i,
  output logic              line_o,
  output logic [IDLE_W-1:0] idle_o
);
  logic [1:0]        sync_q;
  logic [IDLE_W-1:0] idle_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b11;
      idle_q <= '0;
    end else begin
      sync_q <= {sync_q[0], cec_i};
      if (!sync_q[1])                 idle_q <= '0;
      else if (tick_i && idle_q != '1) idle_q <= idle_q + 1'b1;  // saturating
    end
  end

  assign line_o = sync_q[1];
  assign idle_o = idle_q;
endmodule

// File: rtl/cec_tx.sv
module cec_tx
  import cec_tx_pkg::*;
#(
  parameter int unsigned WORDS = 4,
  parameter int unsigned DIV_W = 12,
  parameter int unsigned CNT_W = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        soft_rst_i,
  input  logic [DIV_W-1:0]            div_i,
  input  logic [CNT_W-1:0]            t_start_low_i,
  input  logic [CNT_W-1:0]            t_start_per_i,
  input  logic [CNT_W-1:0]            t_zero_low_i,
  input  logic [CNT_W-1:0]            t_one_low_i,
  input  logic [CNT_W-1:0]            t_bit_per_i,
  input  logic [CNT_W-1:0]            t_samp_i,
  input  logic [WORDS*32-1:0]         msg_i,
  input  logic [$clog2(WORDS*4)-1:0]  len_m1_i,
  input  logic                        start_i,
  input  logic                        cec_i,
  output logic                        cec_drive_o,
  output logic                        busy_o,
  output logic                        eom_o,
  output logic                        good_o,
  output logic                        irq_o
);
  localparam int unsigned NB     = WORDS * 4;
  localparam int unsigned IDX_W  = $clog2(NB);
  localparam int unsigned IDLE_W = CNT_W + 3;

  tx_state_e           state_q;
  logic [CNT_W-1:0]    tcnt_q;
  logic [3:0]          bit_no_q;
  logic [IDX_W-1:0]    byte_no_q, len_q;
  logic [WORDS*32-1:0] msg_q;
  logic                retry_q, ack_q, armed_q, eom_q, good_q, irq_q;

  logic                tick, line;
  logic [IDLE_W-1:0]   idle_cnt, need;
  logic [7:0]          cur_byte;
  logic [2:0]          bsel;
  logic                bit_val, last_byte, ack_slot, bcast, samp, bit_end, lost, ack_now;
  logic [CNT_W-1:0]    low_t;

  cec_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .div_i(div_i), .tick_o(tick)
  );

  cec_line_mon #(.IDLE_W(IDLE_W)) u_mon (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .cec_i(cec_i),
    .line_o(line), .idle_o(idle_cnt)
  );

  cec_byte_sel #(.WORDS(WORDS), .IDX_W(IDX_W)) u_sel (
    .msg_i(msg_q), .idx_i(byte_no_q), .byte_o(cur_byte)
  );

  assign bcast     = (msg_q[3:0] == BCAST_DEST);
  assign last_byte = (byte_no_q == len_q);
  assign ack_slot  = (bit_no_q == 4'(SLOT_ACK));
  assign bsel      = 3'd7 - bit_no_q[2:0];
  assign samp      = tick && (tcnt_q == t_samp_i);
  assign bit_end   = (tcnt_q == t_bit_per_i - 1'b1);
  assign need      = retry_q ? IDLE_W'(t_bit_per_i) * IDLE_W'(IDLE_RETRY)
                             : IDLE_W'(t_bit_per_i) * IDLE_W'(IDLE_FIRST);

  always_comb begin
    if (bit_no_q < 4'(SLOT_EOM))       bit_val = cur_byte[bsel];
    else if (bit_no_q == 4'(SLOT_EOM)) bit_val = last_byte;
    else                               bit_val = 1'b1;  // ack slot sent recessive
  end

  assign low_t   = bit_val ? t_one_low_i : t_zero_low_i;
  assign lost    = samp && !ack_slot && bit_val && !line;
  assign ack_now = bcast ? line : !line;

  always_comb begin
    case (state_q)
      ST_START: cec_drive_o = (tcnt_q < t_start_low_i);
      ST_BITS:  cec_drive_o = (tcnt_q < low_t);
      default:  cec_drive_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      tcnt_q    <= '0;
      bit_no_q  <= '0;
      byte_no_q <= '0;
      len_q     <= '0;
      msg_q     <= '0;
      retry_q   <= 1'b0;
      ack_q     <= 1'b0;
      armed_q   <= 1'b0;
      eom_q     <= 1'b0;
      good_q    <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (!start_i) armed_q <= 1'b1;
      if (soft_rst_i) begin
        state_q <= ST_IDLE;
        tcnt_q  <= '0;
        retry_q <= 1'b0;
        eom_q   <= 1'b0;
        good_q  <= 1'b0;
      end else begin
        case (state_q)
          ST_IDLE: if (start_i && armed_q) begin
            armed_q <= 1'b0;
            msg_q   <= msg_i;
            len_q   <= len_m1_i;
            retry_q <= 1'b0;
            eom_q   <= 1'b0;
            good_q  <= 1'b0;
            state_q <= ST_WAIT;
          end
          ST_WAIT: if (tick && idle_cnt >= need) begin
            state_q <= ST_START;
            tcnt_q  <= '0;
          end
          ST_START: if (tick) begin
            if (tcnt_q == t_start_per_i - 1'b1) begin
              state_q   <= ST_BITS;
              tcnt_q    <= '0;
              bit_no_q  <= '0;
              byte_no_q <= '0;
            end else tcnt_q <= tcnt_q + 1'b1;
          end
          ST_BITS: if (tick) begin
            if (lost) begin
              state_q <= ST_IDLE;
              eom_q   <= 1'b1;
              good_q  <= 1'b0;
              irq_q   <= 1'b1;
            end else begin
              if (samp && ack_slot) ack_q <= ack_now;
              if (bit_end) begin
                tcnt_q <= '0;
                if (ack_slot) begin
                  if (!ack_q) begin
                    if (!retry_q) begin
                      retry_q <= 1'b1;
                      state_q <= ST_WAIT;
                    end else begin
                      state_q <= ST_IDLE;
                      eom_q   <= 1'b1;
                      good_q  <= 1'b0;
                      irq_q   <= 1'b1;
                    end
                  end else if (last_byte) begin
                    state_q <= ST_IDLE;
                    eom_q   <= 1'b1;
                    good_q  <= 1'b1;
                    irq_q   <= 1'b1;
                  end else begin
                    byte_no_q <= byte_no_q + 1'b1;
                    bit_no_q  <= '0;
                  end
                end else bit_no_q <= bit_no_q + 1'b1;
              end else tcnt_q <= tcnt_q + 1'b1;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign eom_o  = eom_q;
  assign good_o = good_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/cec_tx_chk.sv
module cec_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic soft_rst_i,
  input logic start_i,
  input logic cec_drive_o,
  input logic busy_o,
  input logic eom_o,
  input logic irq_o
);
  a_r7_irq_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (eom_o && !busy_o));

  a_r7_irq_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  a_r10_soft_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (!cec_drive_o && !busy_o && !eom_o));

  a_r4_launch_needs_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));

  a_r1_idle_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !cec_drive_o);

  a_r7_end_reason: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (irq_o || $past(soft_rst_i)));
endmodule

bind cec_tx cec_tx_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .soft_rst_i(soft_rst_i), .start_i(start_i),
  .cec_drive_o(cec_drive_o), .busy_o(busy_o), .eom_o(eom_o), .irq_o(irq_o)
);

// File: tb/cec_tx_bench.sv
module cec_tx_bench;
  localparam int WORDS = 4, DIV_W = 12, CNT_W = 8;
  localparam int T_SL = 12, T_SP = 16, T_ZL = 6, T_OL = 2, T_BP = 10, T_SA = 5;

  logic clk = 1'b0, rst_n = 1'b0, soft_rst = 1'b0, start = 1'b0, pull = 1'b0;
  logic [DIV_W-1:0]    div = '0;
  logic [WORDS*32-1:0] msg = '0;
  logic [3:0]          len_m1 = '0;
  logic drive, busy, eom, good, irq, cec_line;

  assign cec_line = ~(drive | pull);
  always #10 clk = ~clk;

  cec_tx #(.WORDS(WORDS), .DIV_W(DIV_W), .CNT_W(CNT_W)) u_cec_tx (
    .clk_i(clk), .rst_ni(rst_n), .soft_rst_i(soft_rst), .div_i(div),
    .t_start_low_i(8'(T_SL)), .t_start_per_i(8'(T_SP)), .t_zero_low_i(8'(T_ZL)),
    .t_one_low_i(8'(T_OL)), .t_bit_per_i(8'(T_BP)), .t_samp_i(8'(T_SA)),
    .msg_i(msg), .len_m1_i(len_m1), .start_i(start), .cec_i(cec_line),
    .cec_drive_o(drive), .busy_o(busy), .eom_o(eom), .good_o(good), .irq_o(irq)
  );

  int n_chk = 0, n_fail = 0;
  // follower model state
  int cyc = 0, frames = 0, nbytes = 0, nbits = 0, bad_pulse = 0, ack_zero = 0, irq_cnt = 0;
  int policy = 1, low_len = 0, rise_t = 0, last_rel = 0, gap1 = 0, gap2 = 0, pull_cnt = 0, bit_no = 0;
  bit in_frame = 0, drv_prev = 0;
  logic [7:0] sh = '0;
  logic [7:0] rx [16];
  bit rx_eom [16];

  function automatic bit want_pull();
    case (policy)
      1: return 1'b1;
      2: return frames >= 2;
      3: return frames == 1;
      default: return 1'b0;
    endcase
  endfunction

  always @(negedge clk) begin
    int ticks, slot, b, gap;
    cyc++;
    if (irq) irq_cnt++;
    if (drive && !drv_prev) begin
      rise_t = cyc;
      low_len = 0;
      if (in_frame && (bit_no % 10) == 9 && want_pull()) pull_cnt = T_ZL * (int'(div) + 1);
      if (in_frame && bit_no == 0 && policy == 4) pull_cnt = T_ZL * (int'(div) + 1);
    end
    if (drive) low_len++;
    if (!drive && drv_prev) begin
      ticks = low_len / (int'(div) + 1);
      if (ticks >= T_SL) begin
        if (ticks != T_SL) bad_pulse++;
        gap = rise_t - last_rel;
        frames++;
        if (frames == 1) gap1 = gap;
        if (frames == 2) gap2 = gap;
        in_frame = 1; bit_no = 0; nbytes = 0;
      end else if (in_frame) begin
        if (ticks != T_OL && ticks != T_ZL) bad_pulse++;
        b = (ticks == T_OL) ? 1 : 0;
        slot = bit_no % 10;
        if (slot < 8) sh = {sh[6:0], b[0]};
        if (slot == 7 && nbytes < 16) rx[nbytes] = sh;
        if (slot == 8 && nbytes < 16) rx_eom[nbytes] = b[0];
        if (slot == 9) begin
          if (b == 0) ack_zero++;
          nbytes++;
        end
        bit_no++;
        nbits++;
      end
      last_rel = cyc;
    end
    drv_prev = drive;
    if (pull_cnt > 0) begin pull = 1'b1; pull_cnt--; end
    else pull = 1'b0;
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clr_fol();
    frames = 0; nbytes = 0; nbits = 0; bad_pulse = 0; ack_zero = 0;
    irq_cnt = 0; in_frame = 0; gap1 = 0; gap2 = 0;
  endtask

  task automatic load(int sd, int len, bit bc);
    for (int k = 0; k < 16; k++) msg[k*8 +: 8] = 8'(k * 37 + sd * 11 + 5);
    msg[7:0] = {4'(sd), 4'(sd % 15)};
    if (bc) msg[3:0] = 4'hF;
    len_m1 = 4'(len - 1);
  endtask

  task automatic run_msg();
    int c;
    clr_fol();
    start = 1'b0;
    step(1);
    start = 1'b1;
    step(2);
    chk(busy && !eom && !good, "R7 flags cleared at launch", int'({busy, eom, good}), 4);
    c = 0;
    while (busy && c < 20000) begin step(1); c++; end
    chk(!busy, "R7 message completes", int'(busy), 0);
    step(2);
  endtask

  task automatic verify(int len, int exp_frames, bit exp_good, int exp_nb);
    int mism, eerr;
    mism = 0; eerr = 0;
    chk(frames == exp_frames, "R6 attempt count", frames, exp_frames);
    chk(eom == 1'b1, "R7 eom set", int'(eom), 1);
    chk(good == exp_good, "R6 good status", int'(good), int'(exp_good));
    chk(irq_cnt == 1, "R7 single irq", irq_cnt, 1);
    chk(bad_pulse == 0 && ack_zero == 0, "R11 R3 pulse widths and ack slot", bad_pulse + ack_zero, 0);
    chk(nbytes == exp_nb, "R2 bytes in last frame", nbytes, exp_nb);
    for (int k = 0; k < exp_nb && k < 16; k++) begin
      if (rx[k] !== msg[k*8 +: 8]) mism++;
      if (rx_eom[k] != (k == len - 1)) eerr++;
    end
    chk(mism == 0, "R2 R3 byte order and content", mism, 0);
    chk(eerr == 0, "R3 eom bit placement", eerr, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int nb;
    step(5);
    chk(!drive && !busy && !eom && !good && !irq, "R1 outputs in reset",
        int'({drive, busy, eom, good, irq}), 0);
    rst_n = 1'b1;
    step(3);
    chk(!drive && !busy && !eom && !good && !irq, "R1 outputs after reset",
        int'({drive, busy, eom, good, irq}), 0);

    // R2 R3: every length, distinct patterns
    policy = 1;
    for (int len = 1; len <= 16; len++) begin
      load(len, len, 1'b0);
      run_msg();
      verify(len, 1, 1'b1, len);
    end

    // R5 first-attempt idle gap after previous message
    load(3, 2, 1'b0);
    run_msg();
    verify(2, 1, 1'b1, 2);
    chk(gap1 >= 70 && gap1 < 90, "R5 first-attempt idle gap", gap1, 77);

    // R6 no acknowledge on either attempt, R5 retry gap
    policy = 0;
    load(4, 3, 1'b0);
    run_msg();
    verify(3, 2, 1'b0, 1);
    chk(gap2 >= 30 && gap2 < 45, "R5 retry idle gap", gap2, 33);

    // R6 acknowledged on retry
    policy = 2;
    load(5, 5, 1'b0);
    run_msg();
    verify(5, 2, 1'b1, 5);

    // R6 acknowledged on first attempt: no retry
    policy = 3;
    load(6, 2, 1'b0);
    run_msg();
    verify(2, 1, 1'b1, 2);

    // R8 broadcast: no pull means accepted
    policy = 0;
    load(7, 4, 1'b1);
    run_msg();
    verify(4, 1, 1'b1, 4);

    // R8 broadcast: pull means rejected, retried once
    policy = 1;
    load(8, 2, 1'b1);
    run_msg();
    verify(2, 2, 1'b0, 1);

    // R9 arbitration loss on first data bit (header 0x80 sends 1 first)
    policy = 4;
    load(9, 4, 1'b0);
    msg[7:0] = 8'h80;
    run_msg();
    step(300);
    chk(frames == 1, "R9 no retry after loss", frames, 1);
    chk(nbits == 1, "R9 stops after lost bit", nbits, 1);
    chk(eom && !good, "R9 failure reported", int'({eom, good}), 2);
    chk(irq_cnt == 1, "R9 single irq", irq_cnt, 1);

    // R4 start held high: no relaunch
    step(400);
    chk(!busy && frames == 1, "R4 no relaunch while start held", frames, 1);
    policy = 1;
    load(10, 3, 1'b0);
    run_msg();
    verify(3, 1, 1'b1, 3);

    // R10 soft reset mid-message
    load(11, 8, 1'b0);
    clr_fol();
    start = 1'b0;
    step(1);
    start = 1'b1;
    step(150);
    chk(busy == 1'b1, "R10 transfer in progress", int'(busy), 1);
    soft_rst = 1'b1;
    step(1);
    chk(!drive && !busy && !eom && !good, "R10 released during soft reset",
        int'({drive, busy, eom, good}), 0);
    step(2);
    soft_rst = 1'b0;
    step(1);
    nb = nbits;
    step(500);
    chk(nbits == nb && !busy && !eom, "R10 aborted message not resumed", nbits, nb);

    // R11 divided tick
    div = 12'd2;
    policy = 1;
    load(12, 3, 1'b0);
    run_msg();
    verify(3, 1, 1'b1, 3);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule